// File: doc/BRIEF.md
# Local Interrupt Pending Evaluator

This block sits beside a processor core and decides, every clock, whether an interrupt should be offered to that core. It keeps a 256-entry request set, a 256-entry in-service set, a task priority value and a global enable. From these it picks the highest-numbered requested vector. It derives the processor priority from the task priority and the highest vector in service. It then compares the two priority classes, which are the upper four bits of an 8-bit vector.

Each cycle the result is one of three outcomes. With nothing to offer, both flags are low. A request that is held back by priority raises `irq_blocked`. A request the core may take raises `irq_valid` with the vector on `irq_vector`. Offering a vector to the core follows valid/ready rules. `irq_valid` never depends on `irq_ready`. A transfer happens only on a cycle where `irq_valid`, `irq_ready` and the core's interrupt-enable flag are all high and the core's one-instruction inhibit is low. While `irq_valid` is high and no transfer happens, the offered vector may still change to a higher one that has just arrived. The request side has no back-pressure: a `raise_valid` pulse is always taken. The local timer raises its fixed vector 0xEF through a dedicated tick input.

Top module: `irq_pend_eval`

## Requirements
- R1: After reset `irq_valid` and `irq_blocked` are low, the enable is clear, task priority is 0x00 and both sets are empty.
- R2: While the enable is clear, `irq_valid` and `irq_blocked` stay low whatever the request set holds.
- R3: The candidate is the highest vector number whose request bit is set. A `raise_valid` pulse sets bit `raise_vector`.
- R4: With the enable set and the request set empty, both `irq_valid` and `irq_blocked` are low.
- R5: If the processor priority is nonzero and the candidate's class (vector bits 7:4) is less than or equal to the processor priority class (bits 7:4), `irq_blocked` is high and `irq_valid` is low. Otherwise `irq_valid` is high with the candidate on `irq_vector`. The two flags are never high together.
- R6: The processor priority equals the task priority when the task priority class is at least the class of the highest in-service vector. Otherwise it equals that in-service class in bits 7:4 with bits 3:0 zero. An empty in-service set counts as class 0.
- R7: A transfer happens only when `irq_valid`, `irq_ready` and `core_if_en` are high and `core_inhibit` is low. On a transfer, the offered vector's request bit is cleared and its in-service bit is set at that edge, and `irq_valid` is low after that same edge.
- R8: An `eoi` pulse clears the highest set in-service bit. With the in-service set empty, it changes nothing.
- R9: A `timer_tick` pulse sets request bit 0xEF.
- R10: The outputs are registered. A change in the request set, the in-service set, the task priority or the enable, made at one edge, shows on the outputs after the next edge.
- R11: In one cycle, a raise of the vector being transferred leaves its request bit set. An `eoi` and a transfer in the same cycle clear the previously highest in-service bit before setting the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raise_valid | input | 1 | Set the request bit named by `raise_vector` |
| raise_vector | input | 8 | Vector to request |
| timer_tick | input | 1 | Local timer expiry, requests vector 0xEF |
| cfg_we | input | 1 | Load `cfg_enable` and `cfg_tpr` |
| cfg_enable | input | 1 | Global enable value to load |
| cfg_tpr | input | 8 | Task priority value to load |
| core_if_en | input | 1 | Core interrupt-enable flag |
| core_inhibit | input | 1 | Core one-instruction interrupt inhibit |
| irq_ready | input | 1 | Core ready to take the offered vector |
| eoi | input | 1 | End of interrupt for the highest in-service vector |
| irq_valid | output | 1 | A vector is offered to the core |
| irq_vector | output | 8 | Offered vector, meaningful while `irq_valid` is high |
| irq_blocked | output | 1 | A request exists but is held back by priority |

## Verification
The bench probes the class boundary in both directions: a task priority equal to the candidate class, one class below it, and a task priority of 0x01 against a class-0 vector. A comparison using strict less-than, or one that ignores the zero-priority exception, would grant or block the wrong one of these. The bench walks the processor priority through its two sources. If the in-service term is dropped, a lower request is granted while a higher vector is still in service. It hits the transfer gating with each qualifier missing in turn. A design that ignored the inhibit or the enable flag would move the vector into service early. It also targets same-cycle collisions: a raise on the vector being taken, and an end-of-interrupt combined with a transfer. With the wrong ordering, the wrong in-service bit survives, and a later 0xF8 request is granted instead of blocked.

// File: rtl/irq_pend_pkg.sv
`timescale 1ns/1ps
package irq_pend_pkg;

  // Outcome of one evaluation pass.
  typedef enum logic [1:0] {
    DEC_NONE = 2'd0,  // nothing to report
    DEC_HELD = 2'd1,  // request exists, priority holds it back
    DEC_TAKE = 2'd2   // request may be offered to the core
  } dec_e;

endpackage

// File: rtl/irq_pend_findhi.sv
`timescale 1ns/1ps
// Highest-set-bit finder: a per-group search followed by a group select.
module irq_pend_findhi #(
  parameter int N     = 256,
  parameter int GROUP = 16
) (
  input  logic [N-1:0]         bits_i,
  output logic                 any_o,
  output logic [$clog2(N)-1:0] idx_o
);
  localparam int NG  = N / GROUP;
  localparam int GW  = $clog2(GROUP);
  localparam int NGW = $clog2(NG);

  logic [NG-1:0]         grp_any;
  logic [NG-1:0][GW-1:0] grp_idx;

  for (genvar g = 0; g < NG; g++) begin : g_grp
    logic [GROUP-1:0] slice;
    logic [GW-1:0]    pos;
    assign slice = bits_i[g*GROUP +: GROUP];
    always_comb begin
      pos = '0;
      for (int b = 0; b < GROUP; b++) begin
        if (slice[b]) pos = GW'(b);
      end
    end
    assign grp_any[g] = |slice;
    assign grp_idx[g] = pos;
  end

  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int g = 0; g < NG; g++) begin
      if (grp_any[g]) begin
        any_o = 1'b1;
        idx_o = {NGW'(g), grp_idx[g]};
      end
    end
  end
endmodule

// File: rtl/irq_pend_bank.sv
`timescale 1ns/1ps
// Bit set with indexed set and clear ports; a set wins over a clear of the same bit.
module irq_pend_bank #(
  parameter int N    = 256,
  parameter int NSET = 1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NSET-1:0]                  set_en,
  input  logic [NSET-1:0][$clog2(N)-1:0]   set_idx,
  input  logic                             clr_en,
  input  logic [$clog2(N)-1:0]             clr_idx,
  output logic [N-1:0]                     bits_q
);
  logic [N-1:0] set_mask;
  logic [N-1:0] clr_mask;

  always_comb begin
    set_mask = '0;
    for (int k = 0; k < NSET; k++) begin
      if (set_en[k]) set_mask[set_idx[k]] = 1'b1;
    end
    clr_mask = '0;
    if (clr_en) clr_mask[clr_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bits_q <= '0;
    else        bits_q <= (bits_q & ~clr_mask) | set_mask;
  end
endmodule

// File: rtl/irq_pend_judge.sv
`timescale 1ns/1ps
// Processor-priority derivation and class comparison.
module irq_pend_judge
  import irq_pend_pkg::*;
#(
  parameter int VW  = 8,
  parameter int SUB = 4
) (
  input  logic          enable_i,
  input  logic          req_any_i,
  input  logic [VW-1:0] req_top_i,
  input  logic          svc_any_i,
  input  logic [VW-1:0] svc_top_i,
  input  logic [VW-1:0] tpr_i,
  output dec_e          dec_o
);
  localparam int CW = VW - SUB;

  logic [CW-1:0] svc_cls;
  logic [CW-1:0] tpr_cls;
  logic [VW-1:0] ppr;

  always_comb begin
    svc_cls = svc_any_i ? svc_top_i[VW-1:SUB] : '0;
    tpr_cls = tpr_i[VW-1:SUB];
    ppr     = (tpr_cls >= svc_cls) ? tpr_i : {svc_cls, {SUB{1'b0}}};
  end

  always_comb begin
    if (!enable_i || !req_any_i)
      dec_o = DEC_NONE;
    else if ((ppr != '0) && (req_top_i[VW-1:SUB] <= ppr[VW-1:SUB]))
      dec_o = DEC_HELD;
    else
      dec_o = DEC_TAKE;
  end
endmodule

// File: rtl/irq_pend_eval.sv
`timescale 1ns/1ps
module irq_pend_eval
  import irq_pend_pkg::*;
#(
  parameter int NVEC      = 256,
  parameter int PRIO_SUB  = 4,
  parameter int GROUP     = 16,
  parameter int TIMER_VEC = 239
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    raise_valid,
  input  logic [$clog2(NVEC)-1:0] raise_vector,
  input  logic                    timer_tick,
  input  logic                    cfg_we,
  input  logic                    cfg_enable,
  input  logic [$clog2(NVEC)-1:0] cfg_tpr,
  input  logic                    core_if_en,
  input  logic                    core_inhibit,
  input  logic                    irq_ready,
  input  logic                    eoi,
  output logic                    irq_valid,
  output logic [$clog2(NVEC)-1:0] irq_vector,
  output logic                    irq_blocked
);
  localparam int            VW   = $clog2(NVEC);
  localparam logic [VW-1:0] TVEC = VW'(TIMER_VEC);

  logic            en_q;
  logic [VW-1:0]   tpr_q;
  logic [NVEC-1:0] irr_q;
  logic [NVEC-1:0] isr_q;
  logic            irr_any;
  logic            isr_any;
  logic [VW-1:0]   irr_top;
  logic [VW-1:0]   isr_top;
  dec_e            dec;
  logic            take_fire;

  assign take_fire = irq_valid & irq_ready & core_if_en & ~core_inhibit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      tpr_q <= '0;
    end else if (cfg_we) begin
      en_q  <= cfg_enable;
      tpr_q <= cfg_tpr;
    end
  end

  irq_pend_bank #(.N(NVEC), .NSET(2)) u_irr (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  ({timer_tick, raise_valid}),
    .set_idx ({TVEC, raise_vector}),
    .clr_en  (take_fire),
    .clr_idx (irq_vector),
    .bits_q  (irr_q)
  );

  irq_pend_bank #(.N(NVEC), .NSET(1)) u_isr (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (take_fire),
    .set_idx (irq_vector),
    .clr_en  (eoi & isr_any),
    .clr_idx (isr_top),
    .bits_q  (isr_q)
  );

  irq_pend_findhi #(.N(NVEC), .GROUP(GROUP)) u_irr_hi (
    .bits_i (irr_q),
    .any_o  (irr_any),
    .idx_o  (irr_top)
  );

  irq_pend_findhi #(.N(NVEC), .GROUP(GROUP)) u_isr_hi (
    .bits_i (isr_q),
    .any_o  (isr_any),
    .idx_o  (isr_top)
  );

  irq_pend_judge #(.VW(VW), .SUB(PRIO_SUB)) u_judge (
    .enable_i  (en_q),
    .req_any_i (irr_any),
    .req_top_i (irr_top),
    .svc_any_i (isr_any),
    .svc_top_i (isr_top),
    .tpr_i     (tpr_q),
    .dec_o     (dec)
  );

  // Registered result; a transfer withdraws the offer at its own edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_valid   <= 1'b0;
      irq_blocked <= 1'b0;
      irq_vector  <= '0;
    end else if (take_fire) begin
      irq_valid   <= 1'b0;
      irq_blocked <= 1'b0;
    end else begin
      irq_valid   <= (dec == DEC_TAKE);
      irq_blocked <= (dec == DEC_HELD);
      irq_vector  <= irr_top;
    end
  end
endmodule

// File: rtl/irq_pend_eval_chk.sv
`timescale 1ns/1ps
module irq_pend_eval_chk #(
  parameter int NVEC = 256
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    en_q,
  input logic [NVEC-1:0]         irr_q,
  input logic [NVEC-1:0]         isr_q,
  input logic                    take_fire,
  input logic                    eoi,
  input logic                    irq_valid,
  input logic [$clog2(NVEC)-1:0] irq_vector,
  input logic                    irq_blocked
);
  a_r2_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> (!irq_valid && !irq_blocked));

  a_r4_empty_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (irr_q == '0) |=> (!irq_valid && !irq_blocked));

  a_r5_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_valid && irq_blocked));

  a_r3_offer_is_requested: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> irr_q[irq_vector]);

  a_r7_accept_moves: assert property (@(posedge clk) disable iff (!rst_n)
    take_fire |=> (!irq_valid && isr_q[$past(irq_vector)]));

  a_r8_eoi_empty_noop: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && (isr_q == '0) && !take_fire) |=> (isr_q == '0));
endmodule

bind irq_pend_eval irq_pend_eval_chk #(.NVEC(NVEC)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .en_q        (en_q),
  .irr_q       (irr_q),
  .isr_q       (isr_q),
  .take_fire   (take_fire),
  .eoi         (eoi),
  .irq_valid   (irq_valid),
  .irq_vector  (irq_vector),
  .irq_blocked (irq_blocked)
);

// File: tb/irq_pend_eval_bench.sv
`timescale 1ns/1ps
module irq_pend_eval_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       raise_valid = 1'b0;
  logic [7:0] raise_vector = 8'h00;
  logic       timer_tick = 1'b0;
  logic       cfg_we = 1'b0;
  logic       cfg_enable = 1'b0;
  logic [7:0] cfg_tpr = 8'h00;
  logic       core_if_en = 1'b1;
  logic       core_inhibit = 1'b0;
  logic       irq_ready = 1'b0;
  logic       eoi = 1'b0;
  logic       irq_valid;
  logic [7:0] irq_vector;
  logic       irq_blocked;

  int    n_cmp = 0;
  int    n_bad = 0;
  int    cyc = 0;
  string cur_tag = "R1";
  localparam int WD_LIMIT = 150000;

  always #10 clk = ~clk;

  irq_pend_eval u_irq_pend_eval (
    .clk(clk), .rst_n(rst_n), .raise_valid(raise_valid), .raise_vector(raise_vector),
    .timer_tick(timer_tick), .cfg_we(cfg_we), .cfg_enable(cfg_enable), .cfg_tpr(cfg_tpr),
    .core_if_en(core_if_en), .core_inhibit(core_inhibit), .irq_ready(irq_ready), .eoi(eoi),
    .irq_valid(irq_valid), .irq_vector(irq_vector), .irq_blocked(irq_blocked)
  );

  // Behavioural reference model.
  bit [255:0] m_irr, m_isr;
  bit         m_en, m_valid, m_blk;
  int         m_vec, m_tpr;

  always @(posedge clk) begin
    int  hi_r, hi_s, cls_s, ppr;
    bit  fire;
    if (!rst_n) begin
      m_irr = '0; m_isr = '0; m_en = 0; m_tpr = 0;
      m_valid = 0; m_blk = 0; m_vec = 0;
    end else begin
      fire = m_valid && irq_ready && core_if_en && !core_inhibit;
      hi_r = -1; hi_s = -1;
      for (int i = 0; i < 256; i++) begin
        if (m_irr[i]) hi_r = i;
        if (m_isr[i]) hi_s = i;
      end
      cls_s = (hi_s < 0) ? 0 : hi_s / 16;
      ppr   = (m_tpr / 16 >= cls_s) ? m_tpr : cls_s * 16;
      if (!fire) begin
        m_valid = 0; m_blk = 0;
        if (m_en && hi_r >= 0) begin
          m_vec = hi_r;
          if (ppr != 0 && hi_r / 16 <= ppr / 16) m_blk = 1;
          else m_valid = 1;
        end
      end else begin
        m_isr[m_vec] = 1'b0;
        if (eoi && hi_s >= 0) m_isr[hi_s] = 1'b0;
        m_isr[m_vec] = 1'b1;
        m_irr[m_vec] = 1'b0;
        m_valid = 0; m_blk = 0;
      end
      if (!fire && eoi && hi_s >= 0) m_isr[hi_s] = 1'b0;
      if (raise_valid) m_irr[raise_vector] = 1'b1;
      if (timer_tick)  m_irr[8'hEF] = 1'b1;
      if (cfg_we) begin m_en = cfg_enable; m_tpr = cfg_tpr; end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // Compare against the model on every clock.
  always @(negedge clk) begin
    if (rst_n) begin
      chk({cur_tag, " model valid"}, irq_valid, m_valid);
      chk({cur_tag, " model blocked"}, irq_blocked, m_blk);
      if (m_valid) chk({cur_tag, " model vector"}, irq_vector, m_vec);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == WD_LIMIT) begin
      n_bad++;
      $display("FAIL watchdog (all requirements): actual=%0d expected<%0d cycles", cyc, WD_LIMIT);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic step(); @(negedge clk); endtask

  task automatic raise(input int v);
    raise_valid = 1'b1; raise_vector = v[7:0]; step(); raise_valid = 1'b0;
  endtask

  task automatic cfg(input bit en, input int t);
    cfg_we = 1'b1; cfg_enable = en; cfg_tpr = t[7:0]; step(); cfg_we = 1'b0;
  endtask

  task automatic expect_out(input string tag, input bit v, input int vec, input bit b);
    chk({tag, " valid"}, irq_valid, v);
    chk({tag, " blocked"}, irq_blocked, b);
    if (v) chk({tag, " vector"}, irq_vector, vec);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; raise_valid = 0; timer_tick = 0; cfg_we = 0; irq_ready = 0; eoi = 0;
    core_if_en = 1; core_inhibit = 0;
    step(); step();
    rst_n = 1'b1;
  endtask

  initial begin
    do_reset();
    cur_tag = "R1";
    expect_out("R1 reset", 0, 0, 0);

    cur_tag = "R2";
    raise(8'h40); step();
    expect_out("R2 disabled", 0, 0, 0);

    cur_tag = "R10";
    cfg(1, 8'h00);
    expect_out("R10 not early", 0, 0, 0);
    step();
    expect_out("R10 one later", 1, 8'h40, 0);

    cur_tag = "R3";
    raise(8'h31); raise(8'h90); step();
    expect_out("R3 highest", 1, 8'h90, 0);

    cur_tag = "R7";
    irq_ready = 1; core_if_en = 0; step();
    expect_out("R7 if flag low", 1, 8'h90, 0);
    core_if_en = 1; core_inhibit = 1; step();
    expect_out("R7 inhibit", 1, 8'h90, 0);
    core_inhibit = 0; step(); irq_ready = 0;
    expect_out("R7 taken drops", 0, 0, 0);
    cur_tag = "R6";
    step();
    expect_out("R6 in-service blocks", 0, 0, 1);

    cur_tag = "R8";
    eoi = 1; step(); eoi = 0; step();
    expect_out("R8 eoi clears", 1, 8'h40, 0);
    eoi = 1; step(); eoi = 0; step();
    expect_out("R8 eoi empty", 1, 8'h40, 0);

    cur_tag = "R5";
    cfg(1, 8'h40); step();
    expect_out("R5 equal class", 0, 0, 1);
    cfg(1, 8'h3F); step();
    expect_out("R5 lower class", 1, 8'h40, 0);

    cur_tag = "R6";
    irq_ready = 1; step(); irq_ready = 0; step();
    expect_out("R6 isr over tpr", 0, 0, 1);
    raise(8'h55); step();
    expect_out("R6 above isr class", 1, 8'h55, 0);
    cfg(1, 8'h50); step();
    expect_out("R6 tpr dominates", 0, 0, 1);

    cur_tag = "R4";
    do_reset();
    cfg(1, 8'h00); step();
    expect_out("R4 empty", 0, 0, 0);
    cur_tag = "R5";
    raise(8'h0F); step();
    expect_out("R5 zero ppr", 1, 8'h0F, 0);
    cfg(1, 8'h01); step();
    expect_out("R5 ppr one", 0, 0, 1);

    cur_tag = "R9";
    do_reset();
    cfg(1, 8'h00);
    timer_tick = 1; step(); timer_tick = 0; step();
    expect_out("R9 timer", 1, 8'hEF, 0);

    cur_tag = "R11";
    irq_ready = 1; raise_valid = 1; raise_vector = 8'hEF; step();
    irq_ready = 0; raise_valid = 0; step();
    expect_out("R11 raise during take", 0, 0, 1);
    raise(8'hF3); step();
    expect_out("R11 higher class", 1, 8'hF3, 0);
    eoi = 1; irq_ready = 1; step(); eoi = 0; irq_ready = 0; step();
    raise(8'hF8); step();
    expect_out("R11 eoi before take", 0, 0, 1);

    cur_tag = "R3 random";
    do_reset();
    cfg(1, 8'h00);
    for (int n = 0; n < 3000; n++) begin
      raise_valid  = ($urandom % 4) == 0;
      raise_vector = 8'($urandom);
      timer_tick   = ($urandom % 16) == 0;
      cfg_we       = ($urandom % 40) == 0;
      cfg_enable   = ($urandom % 8) != 0;
      cfg_tpr      = 8'($urandom);
      core_if_en   = ($urandom % 4) != 0;
      core_inhibit = ($urandom % 8) == 0;
      irq_ready    = ($urandom % 2) == 0;
      eoi          = ($urandom % 5) == 0;
      step();
    end
    raise_valid = 0; timer_tick = 0; cfg_we = 0; irq_ready = 0; eoi = 0;
    step(); step();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule